// File: doc/BRIEF.md
# Thread-Block Residency Admission Controller

This block decides, one request at a time, whether another thread block can be placed on a multiprocessor. It keeps four running totals: resident threads, registers reserved, scratchpad bytes reserved, and occupied block slots. A launch request carries the block's thread count, the registers each thread needs, and the scratchpad bytes the block needs. The block's register cost is its thread count times its registers per thread. The request is accepted only if every total would still be within its limit after adding the whole block. A block is never admitted in part.

The grant and the assigned slot index come back combinationally in the cycle the request is presented, and the totals move at the next clock edge. The block is released later by a retire pulse that names its slot. That pulse subtracts exactly what the slot had reserved.

A separate query port reports the number of blocks of a given shape that could be resident at once on an empty multiprocessor. Whichever resource runs out first sets that number. Scheduling between kernels and warp issue are handled elsewhere.

Top module: `bac_admit`

## Requirements
- R1: After reset all four totals (`used_threads`, `used_regs`, `used_smem`, `used_blocks`) are zero and every slot is free.
- R2: A launch is granted only if all of the following hold after adding the whole block: resident threads stay at or below MAX_THREADS (1536), reserved registers stay at or below REG_FILE (16384), reserved scratchpad bytes stay at or below SMEM_BYTES (16384), and a slot is free. When a launch is refused, no total changes.
- R3: A granted block reserves `launch_threads * launch_rpt` registers, `launch_threads` threads and `launch_smem` bytes. Each of these is added to its total at the next clock edge.
- R4: A request with zero threads is refused. A request with more than MAX_RPT (63) registers per thread is refused. Exactly 63 is allowed.
- R5: A granted block receives the lowest-numbered free slot, in the range 0 to MAX_BLOCKS-1 (0 to 7). No more than MAX_BLOCKS blocks are ever resident.
- R6: A pulse on `retire_valid` with slot `retire_slot` subtracts exactly the threads, registers and bytes that the slot had reserved, and frees the slot. A retire that names an empty slot changes nothing.
- R7: When a retire and a launch arrive in the same cycle, both are applied. The retired block's resources and its slot count as free for that cycle's grant decision.
- R8: `query_blocks` equals the minimum of four values: MAX_THREADS / threads, REG_FILE / (threads * registers per thread), SMEM_BYTES / bytes, and MAX_BLOCKS. A zero register or byte demand places no limit from that resource. A shape with zero threads, or with more than MAX_RPT registers per thread, reports 0.
- R9: `launch_grant` and `launch_slot` are valid combinationally in the cycle the request is presented. They do not depend on any earlier request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | A launch request is present this cycle |
| launch_threads | input | 11 | Threads in the requested block |
| launch_rpt | input | 7 | Registers per thread of the requested block |
| launch_smem | input | 15 | Scratchpad bytes of the requested block |
| launch_grant | output | 1 | The request is admitted this cycle |
| launch_slot | output | 3 | Slot given to the admitted block |
| retire_valid | input | 1 | A resident block finishes this cycle |
| retire_slot | input | 3 | Slot of the finishing block |
| query_threads | input | 11 | Threads per block of the shape being asked about |
| query_rpt | input | 7 | Registers per thread of the asked shape |
| query_smem | input | 15 | Scratchpad bytes per block of the asked shape |
| query_blocks | output | 4 | Blocks of that shape that fit on an empty multiprocessor |
| used_threads | output | 11 | Resident thread total |
| used_regs | output | 15 | Reserved register total |
| used_smem | output | 15 | Reserved scratchpad byte total |
| used_blocks | output | 4 | Occupied slot count |

## Verification
The bench builds the controller with its default parameters: 1536 threads, 16384 registers, 16384 scratchpad bytes, 8 slots and 63 registers per thread. With these values the worked cases come within reach.

- 2 KB blocks fit eight at a time, and 5 KB blocks fit only three.
- Twelve registers per thread cap 256-thread blocks at five.
- Thread totals fill in whole-block steps of 512.
- A block can fill the register file exactly, and the next block is then refused.
- The ninth block is refused because no slot is free.

// File: rtl/bac_pkg.sv
package bac_pkg;

   // Smaller of two unsigned values.
   function automatic int unsigned umin(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction

   // Capacity bound imposed by one resource; a zero demand leaves cap untouched.
   function automatic int unsigned quot_cap(input int unsigned num,
                                            input int unsigned den,
                                            input int unsigned cap);
      if (den == 0) return cap;
      return umin(num / den, cap);
   endfunction

endpackage

// File: rtl/bac_lowest_free.sv
module bac_lowest_free #(
   parameter int SLOTS  = 8,
   parameter int SLOT_W = $clog2(SLOTS)
) (
   input  logic [SLOTS-1:0]  free_mask,
   output logic [SLOT_W-1:0] pick,
   output logic              any
);
   always_comb begin
      pick = '0;
      any  = 1'b0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (free_mask[i]) begin
            pick = SLOT_W'(i);
            any  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/bac_slot_table.sv
module bac_slot_table #(
   parameter int SLOTS  = 8,
   parameter int TW     = 11,
   parameter int RW     = 15,
   parameter int SW     = 15,
   parameter int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [SLOT_W-1:0] alloc_slot,
   input  logic [TW-1:0]     alloc_thr,
   input  logic [RW-1:0]     alloc_regs,
   input  logic [SW-1:0]     alloc_smem,
   input  logic              retire_valid,
   input  logic [SLOT_W-1:0] retire_slot,
   output logic [SLOTS-1:0]  occ,
   output logic [TW-1:0]     ret_thr,
   output logic [RW-1:0]     ret_regs,
   output logic [SW-1:0]     ret_smem,
   output logic              ret_hit
);
   logic [TW-1:0] thr_v  [SLOTS];
   logic [RW-1:0] regs_v [SLOTS];
   logic [SW-1:0] smem_v [SLOTS];

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic          occ_q;
      logic [TW-1:0] thr_q;
      logic [RW-1:0] regs_q;
      logic [SW-1:0] smem_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            occ_q  <= 1'b0;
            thr_q  <= '0;
            regs_q <= '0;
            smem_q <= '0;
         end else if (alloc_en && alloc_slot == SLOT_W'(i)) begin
            occ_q  <= 1'b1;
            thr_q  <= alloc_thr;
            regs_q <= alloc_regs;
            smem_q <= alloc_smem;
         end else if (retire_valid && retire_slot == SLOT_W'(i)) begin
            occ_q  <= 1'b0;
         end
      end
      assign occ[i]    = occ_q;
      assign thr_v[i]  = thr_q;
      assign regs_v[i] = regs_q;
      assign smem_v[i] = smem_q;
   end

   always_comb begin
      ret_hit  = retire_valid && occ[retire_slot];
      ret_thr  = ret_hit ? thr_v[retire_slot]  : '0;
      ret_regs = ret_hit ? regs_v[retire_slot] : '0;
      ret_smem = ret_hit ? smem_v[retire_slot] : '0;
   end

   // R5: a slot is handed out only while free or being vacated this cycle
   assert_slot_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> (!occ[alloc_slot] || (retire_valid && retire_slot == alloc_slot)));

   // R6: a retired slot is empty afterwards unless reused the same cycle
   assert_retire_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_valid && !alloc_en) |=> !occ[$past(retire_slot)]);
endmodule

// File: rtl/bac_capacity.sv
module bac_capacity #(
   parameter int MAX_THREADS = 1536,
   parameter int REG_FILE    = 16384,
   parameter int SMEM_BYTES  = 16384,
   parameter int MAX_BLOCKS  = 8,
   parameter int MAX_RPT     = 63,
   parameter int TW          = 11,
   parameter int PW          = 7,
   parameter int SW          = 15,
   parameter int CW          = 4
) (
   input  logic [TW-1:0] q_thr,
   input  logic [PW-1:0] q_rpt,
   input  logic [SW-1:0] q_smem,
   output logic [CW-1:0] q_cap
);
   import bac_pkg::*;

   int unsigned blk_regs;
   int unsigned c;

   always_comb begin
      blk_regs = 32'(q_thr) * 32'(q_rpt);
      if (q_thr == '0 || 32'(q_rpt) > 32'(MAX_RPT)) begin
         c = 0;
      end else begin
         c = quot_cap(32'(MAX_THREADS), 32'(q_thr), 32'(MAX_BLOCKS));
         c = quot_cap(32'(REG_FILE), blk_regs, c);
         c = quot_cap(32'(SMEM_BYTES), 32'(q_smem), c);
      end
      q_cap = CW'(c);
   end
endmodule

// File: rtl/bac_admit.sv
module bac_admit #(
   parameter int MAX_THREADS = 1536,
   parameter int REG_FILE    = 16384,
   parameter int SMEM_BYTES  = 16384,
   parameter int MAX_BLOCKS  = 8,
   parameter int MAX_RPT     = 63,
   localparam int TW     = $clog2(MAX_THREADS + 1),
   localparam int PW     = $clog2(MAX_RPT + 1) + 1,
   localparam int RW     = $clog2(REG_FILE + 1),
   localparam int SW     = $clog2(SMEM_BYTES + 1),
   localparam int SLOT_W = $clog2(MAX_BLOCKS),
   localparam int CW     = $clog2(MAX_BLOCKS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_valid,
   input  logic [TW-1:0]     launch_threads,
   input  logic [PW-1:0]     launch_rpt,
   input  logic [SW-1:0]     launch_smem,
   output logic              launch_grant,
   output logic [SLOT_W-1:0] launch_slot,
   input  logic              retire_valid,
   input  logic [SLOT_W-1:0] retire_slot,
   input  logic [TW-1:0]     query_threads,
   input  logic [PW-1:0]     query_rpt,
   input  logic [SW-1:0]     query_smem,
   output logic [CW-1:0]     query_blocks,
   output logic [TW-1:0]     used_threads,
   output logic [RW-1:0]     used_regs,
   output logic [SW-1:0]     used_smem,
   output logic [CW-1:0]     used_blocks
);
   if (MAX_BLOCKS < 2) begin : g_chk_blocks
      $error("bac_admit: MAX_BLOCKS must be at least 2");
   end
   if (MAX_THREADS < 1 || REG_FILE < 1 || SMEM_BYTES < 1 || MAX_RPT < 1) begin : g_chk_limits
      $error("bac_admit: resource limits must be positive");
   end

   logic [MAX_BLOCKS-1:0] occ, free_eff, ret_onehot;
   logic [TW-1:0] ret_thr;
   logic [RW-1:0] ret_regs;
   logic [SW-1:0] ret_smem;
   logic          ret_hit;
   logic [SLOT_W-1:0] pick;
   logic          pick_any;
   logic          shape_ok, fit_thr, fit_regs, fit_smem;
   int unsigned   blk_regs;

   bac_slot_table #(.SLOTS(MAX_BLOCKS), .TW(TW), .RW(RW), .SW(SW), .SLOT_W(SLOT_W)) u_slots (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(launch_grant), .alloc_slot(pick),
      .alloc_thr(launch_threads), .alloc_regs(RW'(blk_regs)), .alloc_smem(launch_smem),
      .retire_valid(retire_valid), .retire_slot(retire_slot),
      .occ(occ), .ret_thr(ret_thr), .ret_regs(ret_regs), .ret_smem(ret_smem),
      .ret_hit(ret_hit)
   );

   always_comb begin
      ret_onehot = '0;
      if (ret_hit) ret_onehot[retire_slot] = 1'b1;
      free_eff = ~occ | ret_onehot;
   end

   bac_lowest_free #(.SLOTS(MAX_BLOCKS), .SLOT_W(SLOT_W)) u_pick (
      .free_mask(free_eff), .pick(pick), .any(pick_any)
   );

   always_comb begin
      blk_regs = 32'(launch_threads) * 32'(launch_rpt);
      shape_ok = (launch_threads != '0) && (32'(launch_rpt) <= 32'(MAX_RPT));
      fit_thr  = 32'(used_threads) - 32'(ret_thr) + 32'(launch_threads) <= 32'(MAX_THREADS);
      fit_regs = 32'(used_regs) - 32'(ret_regs) + blk_regs <= 32'(REG_FILE);
      fit_smem = 32'(used_smem) - 32'(ret_smem) + 32'(launch_smem) <= 32'(SMEM_BYTES);
      launch_grant = launch_valid && shape_ok && pick_any && fit_thr && fit_regs && fit_smem;
      launch_slot  = pick;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_threads <= '0;
         used_regs    <= '0;
         used_smem    <= '0;
      end else begin
         used_threads <= used_threads - ret_thr  + (launch_grant ? launch_threads : '0);
         used_regs    <= used_regs    - ret_regs + (launch_grant ? RW'(blk_regs) : '0);
         used_smem    <= used_smem    - ret_smem + (launch_grant ? launch_smem : '0);
      end
   end

   always_comb begin
      used_blocks = '0;
      for (int i = 0; i < MAX_BLOCKS; i++) used_blocks = used_blocks + CW'(occ[i]);
   end

   bac_capacity #(.MAX_THREADS(MAX_THREADS), .REG_FILE(REG_FILE), .SMEM_BYTES(SMEM_BYTES),
                  .MAX_BLOCKS(MAX_BLOCKS), .MAX_RPT(MAX_RPT),
                  .TW(TW), .PW(PW), .SW(SW), .CW(CW)) u_cap (
      .q_thr(query_threads), .q_rpt(query_rpt), .q_smem(query_smem), .q_cap(query_blocks)
   );

   // R2: totals never exceed their limits
   assert_within_limits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      32'(used_threads) <= 32'(MAX_THREADS) && 32'(used_regs) <= 32'(REG_FILE) &&
      32'(used_smem) <= 32'(SMEM_BYTES) && 32'(used_blocks) <= 32'(MAX_BLOCKS));

   // R2: a refusal with no retire leaves every total unchanged
   assert_refuse_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!launch_grant && !retire_valid) |=>
         ($stable(used_threads) && $stable(used_regs) && $stable(used_smem)));

   // R3: an admitted block adds its thread count
   assert_grant_adds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_grant && !retire_valid) |=>
         used_threads == $past(used_threads) + $past(launch_threads));

   // R4: malformed shapes are never admitted
   assert_bad_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_threads == '0 || 32'(launch_rpt) > 32'(MAX_RPT)) |-> !launch_grant);

   // R8: reported capacity never exceeds the slot count
   assert_cap_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      32'(query_blocks) <= 32'(MAX_BLOCKS));
endmodule

// File: tb/sim_bac_admit.sv
`timescale 1ns/100ps
module sim_bac_admit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        launch_valid = 1'b0;
   logic [10:0] launch_threads = '0;
   logic [6:0]  launch_rpt = '0;
   logic [14:0] launch_smem = '0;
   logic        launch_grant;
   logic [2:0]  launch_slot;
   logic        retire_valid = 1'b0;
   logic [2:0]  retire_slot = '0;
   logic [10:0] query_threads = '0;
   logic [6:0]  query_rpt = '0;
   logic [14:0] query_smem = '0;
   logic [3:0]  query_blocks;
   logic [10:0] used_threads;
   logic [14:0] used_regs;
   logic [14:0] used_smem;
   logic [3:0]  used_blocks;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bac_admit u0 (.*);

   typedef struct packed {
      logic [10:0] thr;
      logic [6:0]  rpt;
      logic [14:0] sh;
      logic [3:0]  exp;
   } vec_t;

   localparam vec_t VECS [13] = '{
      '{11'd128,  7'd10, 15'd2048,  4'd8},
      '{11'd128,  7'd10, 15'd5120,  4'd3},
      '{11'd128,  7'd12, 15'd0,     4'd8},
      '{11'd256,  7'd12, 15'd0,     4'd5},
      '{11'd512,  7'd10, 15'd0,     4'd3},
      '{11'd192,  7'd63, 15'd0,     4'd1},
      '{11'd128,  7'd64, 15'd0,     4'd0},
      '{11'd0,    7'd10, 15'd0,     4'd0},
      '{11'd1024, 7'd16, 15'd0,     4'd1},
      '{11'd32,   7'd0,  15'd0,     4'd8},
      '{11'd64,   7'd1,  15'd16384, 4'd1},
      '{11'd1536, 7'd1,  15'd0,     4'd1},
      '{11'd1024, 7'd17, 15'd0,     4'd0}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Present one cycle of stimulus; outputs are then combinationally settled.
   task automatic step(input logic lv, input int t, input int r, input int s,
                       input logic rv, input int rs);
      @(negedge clk);
      launch_valid   = lv;
      launch_threads = 11'(t);
      launch_rpt     = 7'(r);
      launch_smem    = 15'(s);
      retire_valid   = rv;
      retire_slot    = 3'(rs);
      #1;
   endtask

   task automatic idle();
      step(1'b0, 0, 0, 0, 1'b0, 0);
   endtask

   task automatic totals(input string req, input int t, input int r, input int s, input int b);
      chk({req, " threads"}, int'(used_threads), t);
      chk({req, " regs"},    int'(used_regs), r);
      chk({req, " smem"},    int'(used_smem), s);
      chk({req, " blocks"},  int'(used_blocks), b);
   endtask

   task automatic retire_all();
      for (int i = 0; i < 8; i++) step(1'b0, 0, 0, 0, 1'b1, i);
      idle();
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      totals("R1 reset", 0, 0, 0, 0);
      chk("R1 no grant idle", int'(launch_grant), 0);

      // R8: capacity table
      foreach (VECS[i]) begin
         @(negedge clk);
         query_threads = VECS[i].thr;
         query_rpt     = VECS[i].rpt;
         query_smem    = VECS[i].sh;
         #1;
         chk($sformatf("R8 capacity vec %0d", i), int'(query_blocks), int'(VECS[i].exp));
      end

      // R9/R5: same-cycle grants, lowest free slot
      step(1'b1, 128, 12, 5120, 1'b0, 0);
      chk("R9 grant A", int'(launch_grant), 1); chk("R5 slot A", int'(launch_slot), 0);
      step(1'b1, 128, 12, 5120, 1'b0, 0);
      chk("R3 threads after A", int'(used_threads), 128);
      chk("R3 regs after A", int'(used_regs), 1536);
      chk("R5 slot B", int'(launch_slot), 1);
      step(1'b1, 128, 12, 5120, 1'b0, 0);
      chk("R5 slot C", int'(launch_slot), 2);
      step(1'b1, 128, 12, 5120, 1'b0, 0);
      chk("R2 smem overflow refused", int'(launch_grant), 0);
      step(1'b1, 128, 12, 1024, 1'b0, 0);
      chk("R2 smem exact fit", int'(launch_grant), 1); chk("R5 slot E", int'(launch_slot), 3);
      idle();
      totals("R2 after refusal", 512, 6144, 16384, 4);

      // R7: retire and launch together
      step(1'b1, 128, 12, 5120, 1'b1, 1);
      chk("R7 grant with retire", int'(launch_grant), 1);
      chk("R7 reuse slot", int'(launch_slot), 1);
      idle();
      totals("R7 totals", 512, 6144, 16384, 4);

      // R6: retire of empty slot
      step(1'b0, 0, 0, 0, 1'b1, 5);
      idle();
      totals("R6 empty retire", 512, 6144, 16384, 4);

      // R4: shape limits
      step(1'b1, 0, 12, 0, 1'b0, 0);
      chk("R4 zero threads", int'(launch_grant), 0);
      step(1'b1, 32, 64, 0, 1'b0, 0);
      chk("R4 rpt 64", int'(launch_grant), 0);
      step(1'b1, 32, 63, 0, 1'b0, 0);
      chk("R4 rpt 63", int'(launch_grant), 1); chk("R5 slot 4", int'(launch_slot), 4);
      idle();
      totals("R4 totals", 544, 8160, 16384, 5);

      // R6: exact subtraction
      step(1'b0, 0, 0, 0, 1'b1, 3);
      idle();
      totals("R6 retire slot 3", 416, 6624, 15360, 4);
      retire_all();
      totals("R6 all retired", 0, 0, 0, 0);

      // R2: thread limit in whole-block steps
      for (int k = 1; k <= 3; k++) begin
         step(1'b1, 512, 10, 0, 1'b0, 0);
         chk("R2 512-thread grant", int'(launch_grant), 1);
         idle();
         chk("R2 thread step", int'(used_threads), 512 * k);
      end
      step(1'b1, 512, 10, 0, 1'b0, 0);
      chk("R2 thread limit refusal", int'(launch_grant), 0);
      retire_all();

      // R5: slot count limit
      for (int k = 0; k < 8; k++) begin
         step(1'b1, 32, 1, 0, 1'b0, 0);
         chk("R5 slot order", int'(launch_slot), k);
      end
      step(1'b1, 32, 1, 0, 1'b0, 0);
      chk("R5 ninth refused", int'(launch_grant), 0);
      chk("R5 blocks full", int'(used_blocks), 8);
      step(1'b1, 32, 1, 0, 1'b1, 6);
      chk("R7 full reuse grant", int'(launch_grant), 1);
      chk("R7 full reuse slot", int'(launch_slot), 6);
      retire_all();

      // R2: register file exact fill, then refusal
      step(1'b1, 1024, 16, 0, 1'b0, 0);
      chk("R2 regs exact fit", int'(launch_grant), 1);
      step(1'b1, 32, 1, 0, 1'b0, 0);
      chk("R2 regs overflow refused", int'(launch_grant), 0);
      idle();
      totals("R2 regs full", 1024, 16384, 0, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule